// File: doc/BRIEF.md
# Segment LCD Display Mode Engine

This block sits between the pixel memories of a segment LCD controller and its segment drivers. On every frame it decides what each segment shows. It takes a user buffer of segment bits from the pixel memory and keeps its own display buffer. It then applies one of eight display policies to produce the segment vector that goes to the drivers.

Software programs a 3-bit mode and an 8-bit blink divider through a small register port, and the port can be locked by a write-protection input. A written mode is held pending and only becomes the applied mode on the next frame-start strobe, so a frame is never drawn with two policies. Blinking is counted in frames. The blink phase flips once every `divider` frames. A divider of zero keeps the stored pattern visible.

The segment output is a combinational function of:
- the applied mode,
- the blink phase,
- the display buffer,
- the live user-buffer input.

Top module: `seg_mode_engine`

## Requirements
- R1: The control word read back has the mode in bits 2:0 and the blink divider in bits 15:8. Every other bit reads as 0. After reset the whole word is 0.
- R2: While `wp_en` is high, a register write changes neither field.
- R3: A written mode becomes the applied mode only at the next `frame_start`. Until then the output follows the previously applied mode.
- R4: Mode 0 (normal) drives the display buffer. Mode 1 drives all segments to 0. Mode 2 drives all segments to 1.
- R5: Mode 3 drives the display buffer in blink phase 0 and all zeros in phase 1. Mode 5 drives the inverted display buffer in phase 0 and all zeros in phase 1.
- R6: Mode 4 drives the bitwise inverse of the display buffer.
- R7: While mode 6 is being applied at a frame start, the display buffer keeps its contents, and mode 6 drives the display buffer.
- R8: At every frame start whose newly applied mode is not 6, the display buffer takes the user buffer value present at that edge. The display buffer never changes between frame starts.
- R9: Mode 7 drives the live user buffer in phase 0 and the display buffer in phase 1.
- R10: On each frame start with an unchanged mode and a nonzero divider D, the blink phase flips once every D frames. With D = 0 the phase is held at 0.
- R11: A frame start that changes the applied mode clears the blink frame count and sets the phase to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Control word write strobe |
| reg_wr_data | input | 32 | Control word write data |
| wp_en | input | 1 | Write protection, blocks writes when high |
| reg_rd_data | output | 32 | Control word read-back |
| frame_start | input | 1 | One-cycle strobe at the start of each frame |
| usr_buf | input | NSEG | User buffer segment bits |
| dsp_buf | output | NSEG | Display buffer contents |
| seg_out | output | NSEG | Segment values sent to the drivers |

## Verification
The bench sweeps all eight modes against blink dividers 0 to 3. It runs seven frames for each pair and gives every frame a fresh user pattern. The pattern is then flipped in the middle of the frame. That flip tells modes that read the live user input (swap in phase 0) apart from modes that read the display buffer. It also exposes a copy that was wrongly suppressed or wrongly performed in mode 6. The output is also sampled after each mode write and before the next strobe, which separates deferred application from immediate application. Short directed runs with a constant all-ones pattern pin down the exact frame where the blink phase flips, the behaviour with a zero divider, and the phase restart on a mode change. Writes made with protection enabled are checked through the read-back word.

// File: rtl/seg_mode_pkg.sv
package seg_mode_pkg;

  typedef enum logic [2:0] {
    DM_NORMAL    = 3'd0,
    DM_OFF       = 3'd1,
    DM_ON        = 3'd2,
    DM_BLINK     = 3'd3,
    DM_INV       = 3'd4,
    DM_INV_BLINK = 3'd5,
    DM_HOLD      = 3'd6,
    DM_SWAP      = 3'd7
  } disp_mode_e;

  // Value of one segment for a mode, blink phase, user bit and display bit.
  function automatic logic pick_pixel(disp_mode_e m, logic ph, logic u, logic d);
    logic r;
    unique case (m)
      DM_NORMAL, DM_HOLD: r = d;
      DM_OFF:             r = 1'b0;
      DM_ON:              r = 1'b1;
      DM_BLINK:           r = ph ? 1'b0 : d;
      DM_INV:             r = ~d;
      DM_INV_BLINK:       r = ph ? 1'b0 : ~d;
      DM_SWAP:            r = ph ? d : u;
      default:            r = d;
    endcase
    return r;
  endfunction

  // Whether a frame start copies the user buffer into the display buffer.
  function automatic logic copies_on_frame(disp_mode_e m);
    return m != DM_HOLD;
  endfunction

endpackage

// File: rtl/seg_ctrl_reg.sv
module seg_ctrl_reg
  import seg_mode_pkg::*;
#(
  parameter int BLINK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wp_en,
  input  logic [2:0]         wr_mode,
  input  logic [BLINK_W-1:0] wr_div,
  output disp_mode_e         mode_pend,
  output logic [BLINK_W-1:0] blink_div,
  output logic [31:0]        rd_data
);
  localparam int DIV_LSB = 8;

  logic wr_accept;
  assign wr_accept = wr_en && !wp_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_pend <= DM_NORMAL;
      blink_div <= '0;
    end else if (wr_accept) begin
      mode_pend <= disp_mode_e'(wr_mode);
      blink_div <= wr_div;
    end
  end

  always_comb begin
    rd_data = '0;
    rd_data[2:0] = mode_pend;
    rd_data[DIV_LSB +: BLINK_W] = blink_div;
  end
endmodule

// File: rtl/seg_blink_timer.sv
module seg_blink_timer #(
  parameter int BLINK_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_start,
  input  logic               mode_change,
  input  logic [BLINK_W-1:0] div,
  output logic               phase,
  output logic               toggle
);
  logic [BLINK_W-1:0] cnt;
  logic               div_zero;
  logic               wraps;

  // True when one more frame reaches the divider (or has passed it).
  function automatic logic count_wraps(logic [BLINK_W-1:0] c, logic [BLINK_W-1:0] d);
    return ({1'b0, c} + 1'b1) >= {1'b0, d};
  endfunction

  assign div_zero = (div == '0);
  assign wraps    = count_wraps(cnt, div);
  assign toggle   = frame_start && !mode_change && !div_zero && wraps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      phase <= 1'b0;
    end else if (frame_start) begin
      if (mode_change || div_zero) begin
        cnt   <= '0;
        phase <= 1'b0;
      end else if (wraps) begin
        cnt   <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/seg_pixel_lane.sv
module seg_pixel_lane
  import seg_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       copy_en,
  input  logic       usr_bit,
  input  disp_mode_e mode,
  input  logic       phase,
  output logic       dsp_bit,
  output logic       seg_bit
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       dsp_bit <= 1'b0;
    else if (copy_en) dsp_bit <= usr_bit;
  end

  assign seg_bit = pick_pixel(mode, phase, usr_bit, dsp_bit);
endmodule

// File: rtl/seg_mode_engine.sv
module seg_mode_engine
  import seg_mode_pkg::*;
#(
  parameter int NSEG    = 8,
  parameter int BLINK_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr_en,
  input  logic [31:0]     reg_wr_data,
  input  logic            wp_en,
  output logic [31:0]     reg_rd_data,
  input  logic            frame_start,
  input  logic [NSEG-1:0] usr_buf,
  output logic [NSEG-1:0] dsp_buf,
  output logic [NSEG-1:0] seg_out
);
  localparam int DIV_LSB = 8;

  disp_mode_e         mode_pend;
  disp_mode_e         mode_app;
  logic [BLINK_W-1:0] blink_div;
  logic               mode_change;
  logic               blink_phase;
  logic               blink_toggle;
  logic               copy_en;
  logic               wdata_unused;

  assign wdata_unused = ^{reg_wr_data[31:DIV_LSB+BLINK_W], reg_wr_data[DIV_LSB-1:3]};

  seg_ctrl_reg #(.BLINK_W(BLINK_W)) u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .wp_en     (wp_en),
    .wr_mode   (reg_wr_data[2:0]),
    .wr_div    (reg_wr_data[DIV_LSB +: BLINK_W]),
    .mode_pend (mode_pend),
    .blink_div (blink_div),
    .rd_data   (reg_rd_data)
  );

  assign mode_change = frame_start && (mode_pend != mode_app);
  assign copy_en     = frame_start && copies_on_frame(mode_pend);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_app <= DM_NORMAL;
    else if (frame_start) mode_app <= mode_pend;
  end

  seg_blink_timer #(.BLINK_W(BLINK_W)) u_blink (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .mode_change (mode_change),
    .div         (blink_div),
    .phase       (blink_phase),
    .toggle      (blink_toggle)
  );

  for (genvar g = 0; g < NSEG; g++) begin : g_lane
    seg_pixel_lane u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .copy_en (copy_en),
      .usr_bit (usr_buf[g]),
      .mode    (mode_app),
      .phase   (blink_phase),
      .dsp_bit (dsp_buf[g]),
      .seg_bit (seg_out[g])
    );
  end
endmodule

// File: rtl/seg_mode_engine_chk.sv
module seg_mode_engine_chk #(
  parameter int NSEG    = 8,
  parameter int BLINK_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic [31:0]        reg_wr_data,
  input logic               wp_en,
  input logic [31:0]        reg_rd_data,
  input logic               frame_start,
  input logic [NSEG-1:0]    usr_buf,
  input logic [NSEG-1:0]    dsp_buf,
  input logic [NSEG-1:0]    seg_out,
  input logic [2:0]         mode_pend,
  input logic [2:0]         mode_app,
  input logic               mode_change,
  input logic               blink_phase,
  input logic               blink_toggle,
  input logic [BLINK_W-1:0] blink_div
);
  p_rd_layout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[31:16] == '0 && reg_rd_data[7:3] == '0);

  p_wr_take_r1: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && !wp_en |=> reg_rd_data[15:0] == {$past(reg_wr_data[15:8]), 5'b0, $past(reg_wr_data[2:0])});

  p_wp_block_r2: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_en && wp_en |=> $stable(reg_rd_data));

  p_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(mode_app));

  p_apply_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> mode_app == $past(mode_pend));

  p_force_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_app == 3'd1 |-> seg_out == '0);

  p_force_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mode_app == 3'd2 |-> seg_out == '1);

  p_blink_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_app == 3'd3 || mode_app == 3'd5) && blink_phase |-> seg_out == '0);

  p_inverted_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_app == 3'd4 |-> seg_out == ~dsp_buf);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && mode_pend == 3'd6 |=> $stable(dsp_buf));

  p_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && mode_pend != 3'd6 |=> dsp_buf == $past(usr_buf));

  p_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(dsp_buf));

  p_swap_user_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_app == 3'd7 && !blink_phase |-> seg_out == usr_buf);

  p_zero_div_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start && blink_div == '0 |=> !blink_phase);

  p_toggle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    blink_toggle |=> blink_phase != $past(blink_phase));

  p_phase_reset_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_change |=> !blink_phase);
endmodule

bind seg_mode_engine seg_mode_engine_chk #(.NSEG(NSEG), .BLINK_W(BLINK_W)) u_chk (.*);

// File: tb/seg_mode_engine_tb.sv
`timescale 1ns/1ps
module seg_mode_engine_tb;
  localparam int NSEG = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            reg_wr_en = 1'b0;
  logic [31:0]     reg_wr_data = '0;
  logic            wp_en = 1'b0;
  logic [31:0]     reg_rd_data;
  logic            frame_start = 1'b0;
  logic [NSEG-1:0] usr_buf = '0;
  logic [NSEG-1:0] dsp_buf;
  logic [NSEG-1:0] seg_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // Reference state restated from the requirements.
  int              m_pend, m_mode, m_div, m_cnt, m_phase;
  logic [NSEG-1:0] m_dsp;

  always #2 clk = ~clk;

  seg_mode_engine #(.NSEG(NSEG), .BLINK_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
    .wp_en(wp_en), .reg_rd_data(reg_rd_data), .frame_start(frame_start),
    .usr_buf(usr_buf), .dsp_buf(dsp_buf), .seg_out(seg_out)
  );

  function automatic logic [NSEG-1:0] expect_seg(int md, int ph, logic [NSEG-1:0] u, logic [NSEG-1:0] d);
    case (md)
      1: return '0;
      2: return '1;
      3: return (ph != 0) ? '0 : d;
      4: return ~d;
      5: return (ph != 0) ? '0 : ~d;
      7: return (ph != 0) ? d : u;
      default: return d;
    endcase
  endfunction

  function automatic string mode_req(int md);
    case (md)
      3, 5: return "R5";
      4: return "R6";
      6: return "R7";
      7: return "R9";
      default: return "R4";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_out(string req);
    check(req, 32'(seg_out), 32'(expect_seg(m_mode, m_phase, usr_buf, m_dsp)));
  endtask

  task automatic write_reg(int md, int dv, bit prot);
    @(negedge clk);
    wp_en = prot; reg_wr_en = 1'b1;
    reg_wr_data = {16'hFFFF, 8'(dv), 5'b11111, 3'(md)};
    @(negedge clk);
    reg_wr_en = 1'b0; wp_en = 1'b0;
    if (!prot) begin m_pend = md; m_div = dv; end
  endtask

  task automatic frame(logic [NSEG-1:0] u);
    @(negedge clk);
    usr_buf = u; frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    if (m_pend != m_mode || m_div == 0) begin
      m_cnt = 0; m_phase = 0;
    end else if (m_cnt + 1 >= m_div) begin
      m_cnt = 0; m_phase = 1 - m_phase;
    end else begin
      m_cnt++;
    end
    if (m_pend != 6) m_dsp = u;
    m_mode = m_pend;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    m_pend = 0; m_mode = 0; m_div = 0; m_cnt = 0; m_phase = 0; m_dsp = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", reg_rd_data, 32'h0);
    check("R4", 32'(seg_out), 32'h0);

    // R1 layout and R2 protection
    write_reg(5, 8'hC3, 0);
    check("R1", reg_rd_data, 32'h0000_C305);
    write_reg(2, 8'h11, 1);
    check("R2", reg_rd_data, 32'h0000_C305);
    write_reg(0, 0, 0);
    check("R1", reg_rd_data, 32'h0);

    // Sweep of modes and dividers
    for (int md = 0; md < 8; md++) begin
      for (int dv = 0; dv < 4; dv++) begin
        write_reg(md, dv, 0);
        check("R3", 32'(seg_out), 32'(expect_seg(m_mode, m_phase, usr_buf, m_dsp)));
        for (int k = 0; k < 7; k++) begin
          frame(NSEG'(8'hA5 ^ (k * 37) ^ (md * 11) ^ (dv * 70)));
          check_out(mode_req(m_mode));
          check((m_mode == 6) ? "R7" : "R8", 32'(dsp_buf), 32'(m_dsp));
          @(negedge clk);
          usr_buf = ~usr_buf;
          @(negedge clk);
          check_out(mode_req(m_mode));
          check("R8", 32'(dsp_buf), 32'(m_dsp));
        end
      end
    end

    // R10 exact blink frames, divider 2, constant all-ones pattern
    write_reg(0, 0, 0);
    frame('1);
    write_reg(3, 2, 0);
    frame('1); check("R10", 32'(seg_out), 32'hFF);
    frame('1); check("R10", 32'(seg_out), 32'hFF);
    frame('1); check("R10", 32'(seg_out), 32'h00);
    frame('1); check("R10", 32'(seg_out), 32'h00);
    frame('1); check("R10", 32'(seg_out), 32'hFF);
    frame('1); check("R10", 32'(seg_out), 32'hFF);
    frame('1); check("R10", 32'(seg_out), 32'h00);

    // R11 mode change while dark restarts visible
    write_reg(5, 2, 0);
    frame(8'h3C); check("R11", 32'(seg_out), 32'hC3);

    // R10 zero divider holds visible
    write_reg(3, 0, 0);
    frame(8'h5A);
    for (int k = 0; k < 4; k++) begin
      frame(8'h5A); check("R10", 32'(seg_out), 32'h5A);
    end

    // R3 deferral of a force-on write
    write_reg(1, 0, 0);
    frame(8'h0F);
    write_reg(2, 0, 0);
    check("R3", 32'(seg_out), 32'h00);
    frame(8'h0F);
    check("R3", 32'(seg_out), 32'hFF);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule